// File: doc/BRIEF.md
# Protected-Mode Interrupt Entry and Return Sequencer

This block carries out the memory traffic of a protected-mode interrupt. On an accepted vector it reads an 8-byte gate entry from the interrupt table and pushes a three-item return frame onto the stack. It then reads the descriptor of the code segment the gate names and publishes the handler's selector, instruction pointer and code-segment cache fields. The frame width is fixed by the gate type alone: a 16-bit gate gives 16-bit slots and a 32-bit gate gives 32-bit slots. The size bit of any code segment plays no part, so 16-bit and 32-bit interrupted code and handlers can be mixed freely.

The same unit also runs the return: it pops the three items at an operand size given with the request and reports the restored values. It has one memory port, where a request is held until it is acknowledged, and it writes the new stack pointer to an external register through a one-cycle write strobe. Privilege, limit and access-right checks, task gates, error codes and stack switching are not part of it.

Top module: `irq_dispatch_seq`

## Requirements
- R1: The gate entry is read as two 32-bit words, at `idt_base + vec*8` and `idt_base + vec*8 + 4`. Every memory request holds address and data steady until `mem_ack`.
- R2: Gate word 0 carries the selector in bits 31:16 and offset bits 15:0 in bits 15:0. Gate word 1 carries offset bits 31:16 in bits 31:16 and the type in bits 11:8. A type with bit 3 set (0xE) is a 32-bit gate. With protection enabled, a 32-bit gate writes, each as a 32-bit access: flags at sp-4, then the zero-padded CS at sp-8, then EIP at sp-12. The stack pointer is then written as sp-12.
- R3: A gate whose type has bit 3 clear (0x6) writes three 16-bit accesses: flags[15:0] at sp-2, then CS at sp-4, then EIP[15:0] at sp-6. The stack pointer is then written as sp-6. The upper bits of the write data are zero. A size bit set in the handler's descriptor does not widen this frame.
- R4: When `pe` is 0 at acceptance, the frame is always 16-bit and the handler offset is zero-extended, whatever the gate type.
- R5: Once the frame is written, the code-segment descriptor is read as two words at `table + sel[15:3]*8` and `+4`. The table is `ldt_base` when selector bit 2 is 1 and `gdt_base` otherwise. From descriptor word 0 {base[15:0], limit[15:0]} and word 1 {base[31:24], flags[23:20], limit[19:16], access[15:8], base[23:16]}, the outputs are `cs_base`, the 20-bit `cs_limit` and `cs_attr` = {flags, access}.
- R6: `handler_cs` is the gate selector. `handler_eip` is the full 32-bit offset for a 32-bit gate, and the 16-bit offset with zero upper half otherwise. `frame32` reports the frame width used.
- R7: A return reads EIP at sp, then CS at sp+w, then flags at sp+2w, with w = 4 when `ret_op32` is 1 and w = 2 otherwise. It writes sp+3w to the stack pointer and presents the results zero-extended on `ret_eip`, `ret_cs` and `ret_flags`.
- R8: `busy` is high from acceptance to completion. `vec_valid` and `ret_req` have no effect while busy, and no memory request is made while idle. When both arrive in the same idle cycle, the vector wins.
- R9: `done` (entry) and `ret_done` (return) pulse for one cycle, in the cycle `busy` falls, with all results valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pe | input | 1 | Protection enable, sampled with the vector |
| vec_valid | input | 1 | Start interrupt entry |
| vec | input | 8 | Interrupt vector number |
| ret_req | input | 1 | Start return sequence |
| ret_op32 | input | 1 | Return operand size (1 = 32-bit) |
| idt_base | input | 32 | Interrupt table base |
| gdt_base | input | 32 | Global descriptor table base |
| ldt_base | input | 32 | Local descriptor table base |
| sp_in | input | 32 | Current stack pointer |
| flags_in | input | 32 | Flags to save |
| cs_in | input | 16 | Code selector to save |
| eip_in | input | 32 | Instruction pointer to save |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_size32 | output | 1 | 1 = 32-bit access, 0 = 16-bit access |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data, right-aligned |
| mem_ack | input | 1 | Access completed |
| mem_rdata | input | 32 | Read data, right-aligned, valid with ack |
| sp_we | output | 1 | Stack pointer write strobe |
| sp_wdata | output | 32 | New stack pointer |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Entry finished pulse |
| handler_cs | output | 16 | Handler code selector |
| handler_eip | output | 32 | Handler instruction pointer |
| cs_base | output | 32 | Code segment base |
| cs_limit | output | 20 | Code segment limit |
| cs_attr | output | 12 | Code segment flags and access byte |
| frame32 | output | 1 | Width of the last pushed frame |
| ret_done | output | 1 | Return finished pulse |
| ret_eip | output | 32 | Restored instruction pointer |
| ret_cs | output | 16 | Restored code selector |
| ret_flags | output | 32 | Restored flags |

## Verification
The assertions assume that the memory acknowledges only a request it has been given, with one `mem_ack` per access. They also assume that the table bases and the stack pointer stay unchanged while a sequence runs. The bench memory model raises `mem_ack` for exactly one cycle in reply to each held request. The bench changes the bases, `sp_in` and the saved state only while the unit is idle. The vectors and return requests it drives during a sequence are there to be ignored, and they never change the register values the running sequence depends on.

// File: rtl/irq_dispatch_pkg.sv
package irq_dispatch_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GATE0,
    ST_GATE1,
    ST_PUSH,
    ST_DESC0,
    ST_DESC1,
    ST_FIN,
    ST_POP
  } seq_st_t;

  // byte shift from a table index to an 8-byte entry
  localparam int unsigned ENTRY_SHIFT = 3;
  // gate word 1 bit that marks a 32-bit gate (type bit 3)
  localparam int unsigned GATE_WIDE_BIT = 11;

endpackage

// File: rtl/irq_gate_decode.sv
module irq_gate_decode
  import irq_dispatch_pkg::*;
(
  input  logic [31:0] word0,
  input  logic [31:0] word1,
  input  logic        pe_on,
  output logic [15:0] sel,
  output logic [31:0] offset,
  output logic        wide
);
  always_comb begin
    sel    = word0[31:16];
    wide   = pe_on & word1[GATE_WIDE_BIT];
    offset = wide ? {word1[31:16], word0[15:0]} : {16'h0000, word0[15:0]};
  end
endmodule

// File: rtl/irq_seg_decode.sv
module irq_seg_decode (
  input  logic [31:0] word0,
  input  logic [31:0] word1,
  output logic [31:0] base,
  output logic [19:0] limit,
  output logic [11:0] attr
);
  always_comb begin
    base  = {word1[31:24], word1[7:0], word0[31:16]};
    limit = {word1[19:16], word0[15:0]};
    attr  = {word1[23:20], word1[15:8]};
  end
endmodule

// File: rtl/irq_frame_addr.sv
module irq_frame_addr #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] sp_base,
  input  logic          wide,
  input  logic          pop,
  input  logic [1:0]    slot,
  input  logic [31:0]   flags,
  input  logic [15:0]   cs,
  input  logic [31:0]   eip,
  output logic [AW-1:0] addr,
  output logic [31:0]   wdata
);
  logic [AW-1:0] push_step;
  logic [AW-1:0] pop_step;
  logic [31:0]   raw;

  always_comb begin
    // push slot k sits (k+1) units below sp, pop slot k sits k units above
    push_step = AW'({2'b00, slot} + 4'd1) << (wide ? 2 : 1);
    pop_step  = AW'(slot) << (wide ? 2 : 1);
    addr      = pop ? (sp_base + pop_step) : (sp_base - push_step);
    case (slot)
      2'd0:    raw = flags;
      2'd1:    raw = {16'h0000, cs};
      default: raw = eip;
    endcase
    wdata = wide ? raw : {16'h0000, raw[15:0]};
  end
endmodule

// File: rtl/irq_dispatch_seq.sv
module irq_dispatch_seq
  import irq_dispatch_pkg::*;
#(
  parameter int AW    = 32,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pe,
  input  logic             vec_valid,
  input  logic [VEC_W-1:0] vec,
  input  logic             ret_req,
  input  logic             ret_op32,
  input  logic [AW-1:0]    idt_base,
  input  logic [AW-1:0]    gdt_base,
  input  logic [AW-1:0]    ldt_base,
  input  logic [AW-1:0]    sp_in,
  input  logic [31:0]      flags_in,
  input  logic [15:0]      cs_in,
  input  logic [31:0]      eip_in,
  output logic             mem_req,
  output logic             mem_we,
  output logic             mem_size32,
  output logic [AW-1:0]    mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic             mem_ack,
  input  logic [31:0]      mem_rdata,
  output logic             sp_we,
  output logic [AW-1:0]    sp_wdata,
  output logic             busy,
  output logic             done,
  output logic [15:0]      handler_cs,
  output logic [31:0]      handler_eip,
  output logic [31:0]      cs_base,
  output logic [19:0]      cs_limit,
  output logic [11:0]      cs_attr,
  output logic             frame32,
  output logic             ret_done,
  output logic [31:0]      ret_eip,
  output logic [15:0]      ret_cs,
  output logic [31:0]      ret_flags
);
  localparam logic [AW-1:0] WORD_STEP  = AW'(4);
  localparam logic [AW-1:0] FRAME_WIDE = AW'(12);
  localparam logic [AW-1:0] FRAME_NARR = AW'(6);

  seq_st_t          st;
  logic [1:0]       slot;
  logic [VEC_W-1:0] cap_vec;
  logic             cap_pe;
  logic [AW-1:0]    cap_sp;
  logic [31:0]      cap_flags;
  logic [15:0]      cap_cs;
  logic [31:0]      cap_eip;
  logic             ret_wide;
  logic [31:0]      gw0, gw1, dw0, dw1;

  logic [15:0]   g_sel;
  logic [31:0]   g_off;
  logic          g_wide;
  logic [31:0]   s_base;
  logic [19:0]   s_limit;
  logic [11:0]   s_attr;
  logic          f_wide;
  logic          f_pop;
  logic [AW-1:0] f_addr;
  logic [31:0]   f_wdata;
  logic [AW-1:0] gate_addr;
  logic [AW-1:0] desc_addr;

  irq_gate_decode u_gate (
    .word0(gw0), .word1(gw1), .pe_on(cap_pe),
    .sel(g_sel), .offset(g_off), .wide(g_wide)
  );

  irq_seg_decode u_seg (
    .word0(dw0), .word1(dw1),
    .base(s_base), .limit(s_limit), .attr(s_attr)
  );

  assign f_pop  = (st == ST_POP);
  assign f_wide = f_pop ? ret_wide : g_wide;

  irq_frame_addr #(.AW(AW)) u_frame (
    .sp_base(cap_sp), .wide(f_wide), .pop(f_pop), .slot(slot),
    .flags(cap_flags), .cs(cap_cs), .eip(cap_eip),
    .addr(f_addr), .wdata(f_wdata)
  );

  assign gate_addr = idt_base + ({{(AW-VEC_W){1'b0}}, cap_vec} << ENTRY_SHIFT);
  assign desc_addr = (g_sel[2] ? ldt_base : gdt_base)
                   + {{(AW-16){1'b0}}, g_sel[15:3], 3'b000};

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE;  slot <= 2'd0;
      cap_vec <= '0;  cap_pe <= 1'b0;  cap_sp <= '0;
      cap_flags <= '0;  cap_cs <= '0;  cap_eip <= '0;  ret_wide <= 1'b0;
      gw0 <= '0;  gw1 <= '0;  dw0 <= '0;  dw1 <= '0;
      mem_req <= 1'b0;  mem_we <= 1'b0;  mem_size32 <= 1'b0;
      mem_addr <= '0;  mem_wdata <= '0;
      sp_we <= 1'b0;  sp_wdata <= '0;  busy <= 1'b0;  done <= 1'b0;
      handler_cs <= '0;  handler_eip <= '0;  cs_base <= '0;
      cs_limit <= '0;  cs_attr <= '0;  frame32 <= 1'b0;
      ret_done <= 1'b0;  ret_eip <= '0;  ret_cs <= '0;  ret_flags <= '0;
    end else begin
      done     <= 1'b0;
      ret_done <= 1'b0;
      sp_we    <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (vec_valid) begin
            cap_vec <= vec;  cap_pe <= pe;  cap_sp <= sp_in;
            cap_flags <= flags_in;  cap_cs <= cs_in;  cap_eip <= eip_in;
            busy <= 1'b1;  st <= ST_GATE0;
          end else if (ret_req) begin
            cap_sp <= sp_in;  ret_wide <= ret_op32;  slot <= 2'd0;
            busy <= 1'b1;  st <= ST_POP;
          end
        end
        ST_GATE0, ST_GATE1, ST_DESC0, ST_DESC1: begin
          if (!mem_req) begin
            mem_req <= 1'b1;  mem_we <= 1'b0;  mem_size32 <= 1'b1;
            case (st)
              ST_GATE0: mem_addr <= gate_addr;
              ST_GATE1: mem_addr <= gate_addr + WORD_STEP;
              ST_DESC0: mem_addr <= desc_addr;
              default:  mem_addr <= desc_addr + WORD_STEP;
            endcase
          end else if (mem_ack) begin
            mem_req <= 1'b0;
            case (st)
              ST_GATE0: begin gw0 <= mem_rdata; st <= ST_GATE1; end
              ST_GATE1: begin gw1 <= mem_rdata; slot <= 2'd0; st <= ST_PUSH; end
              ST_DESC0: begin dw0 <= mem_rdata; st <= ST_DESC1; end
              default:  begin dw1 <= mem_rdata; st <= ST_FIN; end
            endcase
          end
        end
        ST_PUSH: begin
          if (!mem_req) begin
            mem_req <= 1'b1;  mem_we <= 1'b1;  mem_size32 <= f_wide;
            mem_addr <= f_addr;  mem_wdata <= f_wdata;
          end else if (mem_ack) begin
            mem_req <= 1'b0;  mem_we <= 1'b0;
            if (slot == 2'd2) begin
              sp_we    <= 1'b1;
              sp_wdata <= cap_sp - (g_wide ? FRAME_WIDE : FRAME_NARR);
              slot     <= 2'd0;
              st       <= ST_DESC0;
            end else begin
              slot <= slot + 2'd1;
            end
          end
        end
        ST_FIN: begin
          handler_cs <= g_sel;  handler_eip <= g_off;  frame32 <= g_wide;
          cs_base <= s_base;  cs_limit <= s_limit;  cs_attr <= s_attr;
          done <= 1'b1;  busy <= 1'b0;  st <= ST_IDLE;
        end
        ST_POP: begin
          if (!mem_req) begin
            mem_req <= 1'b1;  mem_we <= 1'b0;  mem_size32 <= ret_wide;
            mem_addr <= f_addr;
          end else if (mem_ack) begin
            mem_req <= 1'b0;
            case (slot)
              2'd0: ret_eip <= ret_wide ? mem_rdata : {16'h0000, mem_rdata[15:0]};
              2'd1: ret_cs  <= mem_rdata[15:0];
              default: begin
                ret_flags <= ret_wide ? mem_rdata : {16'h0000, mem_rdata[15:0]};
                sp_we     <= 1'b1;
                sp_wdata  <= cap_sp + (ret_wide ? FRAME_WIDE : FRAME_NARR);
                ret_done  <= 1'b1;
                busy      <= 1'b0;
                st        <= ST_IDLE;
              end
            endcase
            slot <= slot + 2'd1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_wdata)); // R1
  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_we && !mem_size32 |-> mem_wdata[31:16] == 16'h0000); // R3
  AST_PE_OFF_NARROW: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_we && !cap_pe |-> !mem_size32); // R4
  AST_EIP_UPPER_CLEAR: assert property (@(posedge clk) disable iff (rst)
    done && !frame32 |-> handler_eip[31:16] == 16'h0000); // R6
  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done || ret_done |=> !done && !ret_done); // R9
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    done || ret_done |-> !busy && $past(busy)); // R9

endmodule

// File: tb/irq_dispatch_seq_tb.sv
module irq_dispatch_seq_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst, pe, vec_valid, ret_req, ret_op32;
  logic [7:0]  vec;
  logic [31:0] idt_base, gdt_base, ldt_base, sp_in, flags_in, eip_in;
  logic [15:0] cs_in;
  logic        mem_req, mem_we, mem_size32, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        sp_we, busy, done, frame32, ret_done;
  logic [31:0] sp_wdata, handler_eip, cs_base, ret_eip, ret_flags;
  logic [15:0] handler_cs, ret_cs;
  logic [19:0] cs_limit;
  logic [11:0] cs_attr;

  irq_dispatch_seq u_dut (
    .clk(clk), .rst(rst), .pe(pe), .vec_valid(vec_valid), .vec(vec),
    .ret_req(ret_req), .ret_op32(ret_op32), .idt_base(idt_base),
    .gdt_base(gdt_base), .ldt_base(ldt_base), .sp_in(sp_in),
    .flags_in(flags_in), .cs_in(cs_in), .eip_in(eip_in),
    .mem_req(mem_req), .mem_we(mem_we), .mem_size32(mem_size32),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .sp_we(sp_we), .sp_wdata(sp_wdata),
    .busy(busy), .done(done), .handler_cs(handler_cs),
    .handler_eip(handler_eip), .cs_base(cs_base), .cs_limit(cs_limit),
    .cs_attr(cs_attr), .frame32(frame32), .ret_done(ret_done),
    .ret_eip(ret_eip), .ret_cs(ret_cs), .ret_flags(ret_flags)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;
  logic [31:0] sp_seen;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model: byte array, one-cycle ack per held request
  logic [7:0] mem [0:4095];

  always @(posedge clk) begin
    if (rst) begin
      mem_ack <= 1'b0;
      mem_rdata <= '0;
    end else if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) begin
        mem[mem_addr[11:0]]        = mem_wdata[7:0];
        mem[mem_addr[11:0] + 12'd1] = mem_wdata[15:8];
        if (mem_size32) begin
          mem[mem_addr[11:0] + 12'd2] = mem_wdata[23:16];
          mem[mem_addr[11:0] + 12'd3] = mem_wdata[31:24];
        end
      end else if (mem_size32) begin
        mem_rdata <= {mem[mem_addr[11:0] + 12'd3], mem[mem_addr[11:0] + 12'd2],
                      mem[mem_addr[11:0] + 12'd1], mem[mem_addr[11:0]]};
      end else begin
        mem_rdata <= {16'h0000, mem[mem_addr[11:0] + 12'd1], mem[mem_addr[11:0]]};
      end
    end else begin
      mem_ack <= 1'b0;
    end
  end

  task automatic put32(input logic [31:0] a, input logic [31:0] d);
    mem[a[11:0]]         = d[7:0];
    mem[a[11:0] + 12'd1] = d[15:8];
    mem[a[11:0] + 12'd2] = d[23:16];
    mem[a[11:0] + 12'd3] = d[31:24];
  endtask

  // gate layout from R2
  task automatic put_gate(input logic [7:0] v, input logic [15:0] sel,
                          input logic [31:0] off, input logic [3:0] typ);
    put32(idt_base + {21'd0, v, 3'b000}, {sel, off[15:0]});
    put32(idt_base + {21'd0, v, 3'b000} + 32'd4, {off[31:16], 4'b1000, typ, 8'h00});
  endtask

  // descriptor layout from R5
  task automatic put_desc(input logic [31:0] a, input logic [31:0] base,
                          input logic [19:0] lim, input logic [7:0] acc,
                          input logic [3:0] fl);
    put32(a, {base[15:0], lim[15:0]});
    put32(a + 32'd4, {base[31:24], fl, lim[19:16], acc, base[23:16]});
  endtask

  // scoreboard of expected memory accesses
  typedef struct packed {
    logic        we;
    logic        sz;
    logic [31:0] addr;
    logic [31:0] data;
  } acc_t;
  acc_t  exp_q[$];
  string tag_q[$];

  task automatic expect_acc(input logic we, input logic sz, input logic [31:0] a,
                            input logic [31:0] d, input string tag);
    acc_t e;
    e.we = we; e.sz = sz; e.addr = a; e.data = d;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (!rst && sp_we) sp_seen = sp_wdata;
    if (!rst && mem_req && mem_ack) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R8 unexpected access", mem_addr, 32'h0);
      end else begin
        acc_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(mem_addr == e.addr && mem_we == e.we && mem_size32 == e.sz
            && (!e.we || mem_wdata == e.data),
            {t, " access"}, e.we ? mem_wdata : mem_addr, e.we ? e.data : e.addr);
      end
    end
  end

  task automatic wait_pulse(input bit ret, input string tag);
    int n = 0;
    @(negedge clk);
    while (!(ret ? ret_done : done) && n < 400) begin
      @(negedge clk);
      n++;
    end
    chk(n < 400, {tag, " completion"}, n, 0);
    #1;
  endtask

  task automatic start_int(input logic [7:0] v, input logic p, input logic [31:0] sp,
                           input logic [31:0] fl, input logic [15:0] cs,
                           input logic [31:0] ip);
    @(negedge clk);
    vec = v; pe = p; sp_in = sp; flags_in = fl; cs_in = cs; eip_in = ip;
    vec_valid = 1'b1;
    @(negedge clk);
    vec_valid = 1'b0;
  endtask

  task automatic start_ret(input logic w, input logic [31:0] sp);
    @(negedge clk);
    sp_in = sp; ret_op32 = w; ret_req = 1'b1;
    @(negedge clk);
    ret_req = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; pe = 1'b1; vec_valid = 1'b0; vec = '0; ret_req = 1'b0; ret_op32 = 1'b0;
    idt_base = 32'h100; gdt_base = 32'h400; ldt_base = 32'h600;
    sp_in = '0; flags_in = '0; cs_in = '0; eip_in = '0; sp_seen = '0;
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    put_gate(8'd5, 16'h0010, 32'h1234_5678, 4'hE);
    put_gate(8'd9, 16'h001C, 32'h5555_ABCD, 4'h6);
    put_desc(32'h410, 32'h00A1_B2C3, 20'hFFFFF, 8'h9A, 4'hC);
    put_desc(32'h618, 32'h0001_0000, 20'h0FFFF, 8'h9A, 4'h4);
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R8 reset busy", busy, 0);
    chk(done == 1'b0 && ret_done == 1'b0, "R9 reset done", done, 0);
    chk(mem_req == 1'b0, "R8 reset mem_req", mem_req, 0);

    // 32-bit gate entry
    expect_acc(0, 1, 32'h128, 0, "R1 gate w0");
    expect_acc(0, 1, 32'h12C, 0, "R1 gate w1");
    expect_acc(1, 1, 32'h7FC, 32'h0000_0246, "R2 flags");
    expect_acc(1, 1, 32'h7F8, 32'h0000_0008, "R2 cs");
    expect_acc(1, 1, 32'h7F4, 32'h8765_4321, "R2 eip");
    expect_acc(0, 1, 32'h410, 0, "R5 gdt w0");
    expect_acc(0, 1, 32'h414, 0, "R5 gdt w1");
    start_int(8'd5, 1'b1, 32'h800, 32'h0000_0246, 16'h0008, 32'h8765_4321);
    wait_pulse(1'b0, "R9 entry32");
    chk(busy == 1'b0, "R9 busy low at done", busy, 0);
    chk(handler_cs == 16'h0010, "R6 cs32", handler_cs, 32'h10);
    chk(handler_eip == 32'h1234_5678, "R6 eip32", handler_eip, 32'h1234_5678);
    chk(frame32 == 1'b1, "R6 frame32", frame32, 1);
    chk(sp_seen == 32'h7F4, "R2 sp", sp_seen, 32'h7F4);
    chk(cs_base == 32'h00A1_B2C3, "R5 base", cs_base, 32'h00A1_B2C3);
    chk(cs_limit == 20'hFFFFF, "R5 limit", cs_limit, 32'hFFFFF);
    chk(cs_attr == 12'hC9A, "R5 attr", cs_attr, 32'hC9A);
    chk(exp_q.size() == 0, "R2 all accesses seen", exp_q.size(), 0);

    // 32-bit return from that frame
    expect_acc(0, 1, 32'h7F4, 0, "R7 pop eip32");
    expect_acc(0, 1, 32'h7F8, 0, "R7 pop cs32");
    expect_acc(0, 1, 32'h7FC, 0, "R7 pop flags32");
    start_ret(1'b1, 32'h7F4);
    wait_pulse(1'b1, "R9 return32");
    chk(ret_eip == 32'h8765_4321, "R7 ret eip32", ret_eip, 32'h8765_4321);
    chk(ret_cs == 16'h0008, "R7 ret cs32", ret_cs, 32'h8);
    chk(ret_flags == 32'h0000_0246, "R7 ret flags32", ret_flags, 32'h246);
    chk(sp_seen == 32'h800, "R7 sp32", sp_seen, 32'h800);

    // 16-bit gate through the local table, handler descriptor with size bit set
    expect_acc(0, 1, 32'h148, 0, "R1 gate16 w0");
    expect_acc(0, 1, 32'h14C, 0, "R1 gate16 w1");
    expect_acc(1, 0, 32'h8FE, 32'h0000_0202, "R3 flags");
    expect_acc(1, 0, 32'h8FC, 32'h0000_0030, "R3 cs");
    expect_acc(1, 0, 32'h8FA, 32'h0000_2345, "R3 eip");
    expect_acc(0, 1, 32'h618, 0, "R5 ldt w0");
    expect_acc(0, 1, 32'h61C, 0, "R5 ldt w1");
    start_int(8'd9, 1'b1, 32'h900, 32'h0003_0202, 16'h0030, 32'h0001_2345);
    wait_pulse(1'b0, "R9 entry16");
    chk(handler_cs == 16'h001C, "R6 cs16", handler_cs, 32'h1C);
    chk(handler_eip == 32'h0000_ABCD, "R6 eip16", handler_eip, 32'hABCD);
    chk(frame32 == 1'b0, "R3 frame16", frame32, 0);
    chk(sp_seen == 32'h8FA, "R3 sp", sp_seen, 32'h8FA);
    chk(cs_base == 32'h0001_0000 && cs_attr == 12'h49A, "R5 ldt cache", cs_base, 32'h10000);

    // 16-bit return
    expect_acc(0, 0, 32'h8FA, 0, "R7 pop ip16");
    expect_acc(0, 0, 32'h8FC, 0, "R7 pop cs16");
    expect_acc(0, 0, 32'h8FE, 0, "R7 pop flags16");
    start_ret(1'b0, 32'h8FA);
    wait_pulse(1'b1, "R9 return16");
    chk(ret_eip == 32'h0000_2345, "R7 ret ip16", ret_eip, 32'h2345);
    chk(ret_cs == 16'h0030, "R7 ret cs16", ret_cs, 32'h30);
    chk(ret_flags == 32'h0000_0202, "R7 ret flags16", ret_flags, 32'h202);
    chk(sp_seen == 32'h900, "R7 sp16", sp_seen, 32'h900);

    // protection off: 32-bit gate still gives a 16-bit frame
    expect_acc(0, 1, 32'h128, 0, "R4 gate w0");
    expect_acc(0, 1, 32'h12C, 0, "R4 gate w1");
    expect_acc(1, 0, 32'hA00 - 32'd2, 32'h0000_0246, "R4 flags");
    expect_acc(1, 0, 32'hA00 - 32'd4, 32'h0000_0008, "R4 cs");
    expect_acc(1, 0, 32'hA00 - 32'd6, 32'h0000_4321, "R4 eip");
    expect_acc(0, 1, 32'h410, 0, "R4 desc w0");
    expect_acc(0, 1, 32'h414, 0, "R4 desc w1");
    start_int(8'd5, 1'b0, 32'hA00, 32'h0000_0246, 16'h0008, 32'h8765_4321);
    wait_pulse(1'b0, "R9 entry pe0");
    chk(handler_eip == 32'h0000_5678, "R4 eip", handler_eip, 32'h5678);
    chk(frame32 == 1'b0, "R4 frame", frame32, 0);
    chk(sp_seen == 32'hA00 - 32'd6, "R4 sp", sp_seen, 32'hA00 - 32'd6);

    // requests while busy are ignored
    expect_acc(0, 1, 32'h128, 0, "R8 gate w0");
    expect_acc(0, 1, 32'h12C, 0, "R8 gate w1");
    expect_acc(1, 1, 32'hB00 - 32'd4, 32'h0000_0246, "R8 flags");
    expect_acc(1, 1, 32'hB00 - 32'd8, 32'h0000_0008, "R8 cs");
    expect_acc(1, 1, 32'hB00 - 32'd12, 32'h8765_4321, "R8 eip");
    expect_acc(0, 1, 32'h410, 0, "R8 desc w0");
    expect_acc(0, 1, 32'h414, 0, "R8 desc w1");
    start_int(8'd5, 1'b1, 32'hB00, 32'h0000_0246, 16'h0008, 32'h8765_4321);
    chk(busy == 1'b1, "R8 busy during entry", busy, 1);
    vec = 8'd9; vec_valid = 1'b1; ret_req = 1'b1; ret_op32 = 1'b0;
    repeat (5) @(negedge clk);
    vec_valid = 1'b0; ret_req = 1'b0;
    wait_pulse(1'b0, "R9 entry busy test");
    chk(handler_cs == 16'h0010, "R8 first vector kept", handler_cs, 32'h10);
    repeat (20) @(negedge clk);
    chk(busy == 1'b0, "R8 no second sequence", busy, 0);
    chk(exp_q.size() == 0, "R8 queue drained", exp_q.size(), 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule